// File: doc/BRIEF.md
# Configuration Upload Sequencer

This block takes a byte stream of four-byte command packets and drives the configuration handshake of a downstream programmable device. A start command raises the target's init line and waits for its program-ready input. Once the target reports ready, each data packet's fixed-size payload goes out byte by byte on a valid/ready configuration port, in arrival order. Payload padding bytes are forwarded like any other byte. An end command drops init and watches the target's done input for a bounded number of cycles. A fixed-length response then reports the outcome in its first byte.

Every packet opens with the lead byte 0x0E, then a command code, an argument byte and a zero terminator. Data packets (code 0x22) carry a payload of `PAYLOAD_LEN` bytes (60 by default) right after the header. A data packet that arrives outside the loading phase is consumed and discarded, and the error flag is set. A framing fault also sets the error flag. Both target inputs pass through a `SYNC_STAGES`-deep synchronizer before the sequencer sees them.

Top module: `cfg_upload_seq`

## Requirements
- R1: An accepted start packet (0x0E, 0x21, any argument, 0x00) raises `tgt_init` from the next cycle and clears `seq_err` in that same cycle.
- R2: While init is raised and the block waits, a high `tgt_prog_rdy` seen after `SYNC_STAGES` register stages moves the block into loading. `tgt_init` stays high while the block loads.
- R3: In loading, a data packet (0x0E, 0x22, 0x00, 0x00) is followed by exactly `PAYLOAD_LEN` payload bytes. These appear on `cfg_valid`/`cfg_data` in arrival order, and zero padding bytes are included.
- R4: While a payload is forwarded, `in_ready` equals `cfg_ready`. Each byte is transferred once, with no loss and no repeat.
- R5: A data packet accepted while the block is not loading has its `PAYLOAD_LEN` payload bytes consumed with `cfg_valid` held low, and it sets `seq_err`.
- R6: An accepted end packet (0x0E, 0x23, 0x00, 0x00) drops `tgt_init` from the next cycle. A synchronized `tgt_done` that is high on any of the next `DONE_TIMEOUT` clock edges gives status 0x01.
- R7: If synchronized `tgt_done` stays low for all `DONE_TIMEOUT` edges after the end packet, the status is 0x00.
- R8: The response is `RSP_LEN` bytes on `rsp_valid`/`rsp_data` with a `rsp_ready` handshake. Byte 0 is the status and every later byte is 0x00. `in_ready` is low from the end packet until the last response byte is taken.
- R9: A byte other than 0x0E in the lead position is dropped and sets `seq_err`. A packet whose fourth byte is not 0x00 is ignored and sets `seq_err`.
- R10: A well-formed packet with any other command code is consumed with no effect on init, state or `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command stream byte valid |
| in_data | input | 8 | Command stream byte |
| in_ready | output | 1 | Command stream byte accepted when high with in_valid |
| cfg_valid | output | 1 | Configuration byte valid |
| cfg_data | output | 8 | Configuration byte to the target |
| cfg_ready | input | 1 | Target takes configuration byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte (status in byte 0) |
| rsp_ready | input | 1 | Response byte taken |
| tgt_init | output | 1 | Target init line, high while loading is armed |
| tgt_prog_rdy | input | 1 | Target ready to receive configuration |
| tgt_done | input | 1 | Target configuration complete |
| seq_err | output | 1 | Sticky error flag, cleared by a start packet |

## Verification
The payload path is driven three ways. The first uses a steady ready and an arithmetic byte pattern, which exposes ordering and off-by-one count faults. The second uses a short chunk padded with zeros under pseudo-random backpressure, which exposes lost or repeated bytes and padding that gets dropped. The third is a packet sent after a malformed and an unknown command, which shows that neither one disturbed the loading state. Data packets are also sent while the block is idle and while it waits for ready, which separates forwarding from discarding. The status path is run once with done rising inside the window and once with done never rising, and the response is read under a toggling ready, so the pass status, the fail status and the zero fill are all seen.

// File: rtl/cus_pkg.sv
package cus_pkg;

   localparam logic [7:0] HDR_LEAD  = 8'h0E;
   localparam logic [7:0] CMD_START = 8'h21;
   localparam logic [7:0] CMD_DATA  = 8'h22;
   localparam logic [7:0] CMD_END   = 8'h23;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_WAIT,
      SEQ_LOAD,
      SEQ_CHECK,
      SEQ_RESP
   } seq_st_e;

   typedef enum logic [2:0] {
      FR_H0,
      FR_H1,
      FR_H2,
      FR_H3,
      FR_PAY
   } frame_pos_e;

endpackage

// File: rtl/cus_sync.sv
module cus_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("cus_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            end else begin
               chain_q[0] <= d;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/cus_framer.sv
module cus_framer
   import cus_pkg::*;
#(
   parameter int PAYLOAD_LEN = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_fire,
   input  logic [7:0] byte_val,
   output logic       cmd_ok,
   output logic [7:0] cmd_code,
   output logic       frame_err,
   output logic       in_payload,
   output logic       pay_last
);

   localparam int CW = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(PAYLOAD_LEN - 1);

   frame_pos_e    pos_q;
   logic [7:0]    cmd_q;
   logic [CW-1:0] cnt_q;
   logic          lead_bad;
   logic          term_bad;

   always_comb begin
      lead_bad   = (pos_q == FR_H0) && (byte_val != HDR_LEAD);
      term_bad   = (pos_q == FR_H3) && (byte_val != 8'h00);
      cmd_ok     = byte_fire && (pos_q == FR_H3) && (byte_val == 8'h00);
      frame_err  = byte_fire && (lead_bad || term_bad);
      in_payload = (pos_q == FR_PAY);
      pay_last   = in_payload && byte_fire && (cnt_q == CNT_LAST);
      cmd_code   = cmd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= FR_H0;
         cmd_q <= 8'h00;
         cnt_q <= '0;
      end else if (byte_fire) begin
         unique case (pos_q)
            FR_H0: if (!lead_bad) pos_q <= FR_H1;
            FR_H1: begin
               cmd_q <= byte_val;
               pos_q <= FR_H2;
            end
            FR_H2: pos_q <= FR_H3;
            FR_H3: begin
               if (cmd_ok && (cmd_q == CMD_DATA)) begin
                  pos_q <= FR_PAY;
                  cnt_q <= '0;
               end else begin
                  pos_q <= FR_H0;
               end
            end
            FR_PAY: begin
               if (cnt_q == CNT_LAST) begin
                  pos_q <= FR_H0;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: pos_q <= FR_H0;
         endcase
      end
   end

endmodule

// File: rtl/cus_done_timer.sv
module cus_done_timer #(
   parameter int DONE_TIMEOUT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic done_s,
   output logic res_valid,
   output logic res_pass
);

   localparam int TW = $clog2(DONE_TIMEOUT + 1);
   localparam logic [TW-1:0] T_LAST = TW'(DONE_TIMEOUT - 1);

   logic          active_q;
   logic [TW-1:0] cnt_q;

   always_comb begin
      res_pass  = done_s;
      res_valid = active_q && (done_s || (cnt_q == T_LAST));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (arm) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (res_valid) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cus_resp_tx.sv
module cus_resp_tx #(
   parameter int RSP_LEN = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       pass,
   input  logic       rsp_ready,
   output logic       rsp_valid,
   output logic [7:0] rsp_data,
   output logic       finish
);

   localparam int IW = (RSP_LEN > 1) ? $clog2(RSP_LEN) : 1;
   localparam logic [IW-1:0] IDX_LAST = IW'(RSP_LEN - 1);

   logic          active_q;
   logic          pass_q;
   logic [IW-1:0] idx_q;
   logic          fire;

   always_comb begin
      rsp_valid = active_q;
      rsp_data  = (idx_q == '0) ? {7'b0, pass_q} : 8'h00;
      fire      = active_q && rsp_ready;
      finish    = fire && (idx_q == IDX_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pass_q   <= 1'b0;
         idx_q    <= '0;
      end else if (load) begin
         active_q <= 1'b1;
         pass_q   <= pass;
         idx_q    <= '0;
      end else if (fire) begin
         if (finish) active_q <= 1'b0;
         else        idx_q    <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/cfg_upload_seq.sv
module cfg_upload_seq
   import cus_pkg::*;
#(
   parameter int PAYLOAD_LEN  = 60,
   parameter int RSP_LEN      = 64,
   parameter int DONE_TIMEOUT = 1024,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic       in_ready,
   output logic       cfg_valid,
   output logic [7:0] cfg_data,
   input  logic       cfg_ready,
   output logic       rsp_valid,
   output logic [7:0] rsp_data,
   input  logic       rsp_ready,
   output logic       tgt_init,
   input  logic       tgt_prog_rdy,
   input  logic       tgt_done,
   output logic       seq_err
);

   generate
      if (PAYLOAD_LEN < 1) begin : g_chk_pay
         $error("cfg_upload_seq: PAYLOAD_LEN must be at least 1");
      end
      if (RSP_LEN < 2) begin : g_chk_rsp
         $error("cfg_upload_seq: RSP_LEN must be at least 2");
      end
      if (DONE_TIMEOUT < 1) begin : g_chk_to
         $error("cfg_upload_seq: DONE_TIMEOUT must be at least 1");
      end
   endgenerate

   seq_st_e    st_q;
   logic       fwd_q;
   logic       err_q;
   logic       prog_s;
   logic       done_s;
   logic [1:0] sync_o;
   logic       fire;
   logic       accepting;
   logic       cmd_ok;
   logic [7:0] cmd_code;
   logic       frame_err;
   logic       in_payload;
   logic       pay_last;
   logic       is_start;
   logic       is_end;
   logic       is_data;
   logic       res_valid;
   logic       res_pass;
   logic       rsp_finish;

   cus_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({tgt_done, tgt_prog_rdy}),
      .q     (sync_o)
   );
   assign prog_s = sync_o[0];
   assign done_s = sync_o[1];

   always_comb begin
      accepting = (st_q == SEQ_IDLE) || (st_q == SEQ_WAIT) || (st_q == SEQ_LOAD);
      in_ready  = accepting && (!in_payload || !fwd_q || cfg_ready);
      fire      = in_valid && in_ready;
      cfg_valid = in_payload && fwd_q && in_valid;
      cfg_data  = in_data;
      is_start  = cmd_ok && (cmd_code == CMD_START);
      is_end    = cmd_ok && (cmd_code == CMD_END);
      is_data   = cmd_ok && (cmd_code == CMD_DATA);
      tgt_init  = (st_q == SEQ_WAIT) || (st_q == SEQ_LOAD);
      seq_err   = err_q;
   end

   cus_framer #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_fire  (fire),
      .byte_val   (in_data),
      .cmd_ok     (cmd_ok),
      .cmd_code   (cmd_code),
      .frame_err  (frame_err),
      .in_payload (in_payload),
      .pay_last   (pay_last)
   );

   cus_done_timer #(.DONE_TIMEOUT(DONE_TIMEOUT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (is_end),
      .done_s    (done_s),
      .res_valid (res_valid),
      .res_pass  (res_pass)
   );

   cus_resp_tx #(.RSP_LEN(RSP_LEN)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (res_valid),
      .pass      (res_pass),
      .rsp_ready (rsp_ready),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .finish    (rsp_finish)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SEQ_IDLE;
      end else if (is_start) begin
         st_q <= SEQ_WAIT;
      end else if (is_end) begin
         st_q <= SEQ_CHECK;
      end else begin
         unique case (st_q)
            SEQ_WAIT:  if (prog_s)     st_q <= SEQ_LOAD;
            SEQ_CHECK: if (res_valid)  st_q <= SEQ_RESP;
            SEQ_RESP:  if (rsp_finish) st_q <= SEQ_IDLE;
            default:   st_q <= st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (is_data) fwd_q <= (st_q == SEQ_LOAD);
         else if (pay_last) fwd_q <= 1'b0;
         if (is_start) err_q <= 1'b0;
         else if (frame_err || (is_data && (st_q != SEQ_LOAD))) err_q <= 1'b1;
      end
   end

endmodule

// File: rtl/cus_checker.sv
module cus_checker #(
   parameter int RSP_LEN = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_ready,
   input logic       cfg_valid,
   input logic       cfg_ready,
   input logic       rsp_valid,
   input logic       rsp_ready,
   input logic [7:0] rsp_data,
   input logic       tgt_init,
   input logic       seq_err
);

   logic [15:0] rsp_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rsp_pos <= '0;
      else if (!rsp_valid)             rsp_pos <= '0;
      else if (rsp_ready)              rsp_pos <= rsp_pos + 1'b1;
   end

   AST_CFG_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> tgt_init); // R3
   AST_PAY_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (in_ready == cfg_ready)); // R4
   AST_NO_INPUT_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !in_ready); // R8
   AST_RSP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !tgt_init); // R6
   AST_RSP_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_pos != 16'd0)) |-> (rsp_data == 8'h00)); // R8
   AST_STATUS_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_pos == 16'd0)) |-> (rsp_data[7:1] == 7'd0)); // R8
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready && (rsp_pos < 16'(RSP_LEN))) |=> (rsp_valid && $stable(rsp_data))); // R8
   AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_init) |-> !seq_err); // R1

endmodule

bind cfg_upload_seq cus_checker #(.RSP_LEN(RSP_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .cfg_valid (cfg_valid),
   .cfg_ready (cfg_ready),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_data  (rsp_data),
   .tgt_init  (tgt_init),
   .seq_err   (seq_err)
);

// File: tb/sim_cfg_upload_seq.sv
`timescale 1ns/1ps
module sim_cfg_upload_seq;

   localparam int PLEN = 60;
   localparam int RLEN = 64;
   localparam int TOUT = 40;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic in_ready;
   logic cfg_valid;
   logic [7:0] cfg_data;
   logic cfg_ready = 1'b1;
   logic rsp_valid;
   logic [7:0] rsp_data;
   logic rsp_ready = 1'b1;
   logic tgt_init;
   logic tgt_prog_rdy = 1'b0;
   logic tgt_done = 1'b0;
   logic seq_err;

   int checks = 0;
   int fails = 0;
   bit cfg_rnd = 0;
   bit rsp_rnd = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [7:0] got_cfg [$];
   logic [7:0] exp_cfg [$];
   logic [7:0] got_rsp [$];

   always #2 clk = ~clk;

   cfg_upload_seq #(
      .PAYLOAD_LEN(PLEN), .RSP_LEN(RLEN), .DONE_TIMEOUT(TOUT), .SYNC_STAGES(SYNC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
      .tgt_init(tgt_init), .tgt_prog_rdy(tgt_prog_rdy), .tgt_done(tgt_done), .seq_err(seq_err)
   );

   // behavioural reference: 0 idle, 1 wait, 2 load, 3 check, 4 resp
   int m_st = 0, m_pos = 0, m_pc = 0, m_cnt = 0, m_idx = 0;
   int m_cmd = 0;
   bit m_fwd = 0, m_err = 0, m_stat = 0;
   bit pr_h [$];
   bit dn_h [$];

   function automatic bit m_ready();
      return (m_st <= 2) && (m_pos != 4 || !m_fwd || cfg_ready);
   endfunction

   task automatic check(string tag, int got, int exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   initial begin
      for (int i = 0; i < SYNC; i++) begin pr_h.push_back(0); dn_h.push_back(0); end
   end

   always @(posedge clk) begin
      bit pr, dn, fire, evt;
      int st_old;
      if (!rst_n) begin
         m_st = 0; m_pos = 0; m_pc = 0; m_cnt = 0; m_idx = 0; m_fwd = 0; m_err = 0; m_stat = 0;
         for (int i = 0; i < SYNC; i++) begin pr_h[i] = 0; dn_h[i] = 0; end
      end else begin
         pr = pr_h.pop_front(); pr_h.push_back(tgt_prog_rdy);
         dn = dn_h.pop_front(); dn_h.push_back(tgt_done);
         fire = in_valid && m_ready();
         st_old = m_st;
         evt = 0;
         if (cfg_valid && cfg_ready) got_cfg.push_back(cfg_data);
         if (rsp_valid && rsp_ready) got_rsp.push_back(rsp_data);
         if (fire) begin
            case (m_pos)
               0: if (in_data == 8'h0E) m_pos = 1; else m_err = 1;
               1: begin m_cmd = in_data; m_pos = 2; end
               2: m_pos = 3;
               3: begin
                  m_pos = 0;
                  if (in_data != 0) m_err = 1;
                  else if (m_cmd == 'h21) begin m_st = 1; m_err = 0; evt = 1; end
                  else if (m_cmd == 'h23) begin m_st = 3; m_cnt = 0; evt = 1; end
                  else if (m_cmd == 'h22) begin
                     m_pos = 4; m_pc = 0; m_fwd = (st_old == 2);
                     if (st_old != 2) m_err = 1;
                  end
               end
               default: begin
                  m_pc++;
                  if (m_pc == PLEN) begin m_pos = 0; m_fwd = 0; end
               end
            endcase
         end
         if (!evt) begin
            if (st_old == 1 && pr) m_st = 2;
            else if (st_old == 3) begin
               if (dn) begin m_stat = 1; m_st = 4; m_idx = 0; end
               else if (m_cnt == TOUT - 1) begin m_stat = 0; m_st = 4; m_idx = 0; end
               else m_cnt++;
            end else if (st_old == 4 && rsp_ready) begin
               if (m_idx == RLEN - 1) m_st = 0; else m_idx++;
            end
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1/R2/R6 tgt_init", tgt_init, (m_st == 1 || m_st == 2));
         check("R5/R9 seq_err", seq_err, m_err);
         check("R4/R8 in_ready", in_ready, m_ready());
         check("R3/R5 cfg_valid", cfg_valid, (m_pos == 4 && m_fwd && in_valid));
         if (cfg_valid) check("R3 cfg_data", cfg_data, in_data);
         check("R8 rsp_valid", rsp_valid, (m_st == 4));
         if (rsp_valid) check("R8 rsp_data", rsp_data, (m_idx == 0) ? m_stat : 0);
      end
   end

   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cfg_ready = cfg_rnd ? lfsr[0] : 1'b1;
      rsp_ready = rsp_rnd ? lfsr[5] : 1'b1;
   end

   task automatic send_byte(logic [7:0] b);
      in_valid = 1'b1;
      in_data = b;
      forever begin
         @(negedge clk);
         if (in_ready) begin
            @(posedge clk); #1;
            break;
         end
      end
      in_valid = 1'b0;
   endtask

   task automatic send_cmd(logic [7:0] c, logic [7:0] a, logic [7:0] t);
      send_byte(8'h0E); send_byte(c); send_byte(a); send_byte(t);
   endtask

   task automatic send_data(int kind, int seed, int nreal, bit expect_fwd);
      logic [7:0] b;
      send_cmd(8'h22, 8'h00, 8'h00);
      for (int i = 0; i < PLEN; i++) begin
         b = (i < nreal) ? 8'((kind == 0) ? (i * 7 + seed) : (i ^ seed) + 8'h11) : 8'h00;
         if (expect_fwd) exp_cfg.push_back(b);
         send_byte(b);
      end
   endtask

   task automatic cmp_cfg(string tag);
      check({tag, " byte count"}, got_cfg.size(), exp_cfg.size());
      for (int i = 0; i < exp_cfg.size() && i < got_cfg.size(); i++)
         if (got_cfg[i] !== exp_cfg[i]) check({tag, " byte"}, got_cfg[i], exp_cfg[i]);
      got_cfg.delete(); exp_cfg.delete();
   endtask

   task automatic read_rsp(int exp_status, string tag);
      int k = 0;
      while (got_rsp.size() < RLEN && k < 2000) begin @(posedge clk); k++; end
      #1;
      check({tag, " rsp length"}, got_rsp.size(), RLEN);
      if (got_rsp.size() > 0) check({tag, " status byte"}, got_rsp[0], exp_status);
      for (int i = 1; i < got_rsp.size(); i++)
         if (got_rsp[i] !== 8'h00) check("R8 padding byte", got_rsp[i], 0);
      got_rsp.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      check("reset tgt_init", tgt_init, 0);
      check("reset seq_err", seq_err, 0);
      check("reset rsp_valid", rsp_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk); #1;

      // R5: data packet while idle is swallowed
      send_data(0, 3, PLEN, 0);
      cmp_cfg("R5 idle drop");
      check("R5 err after idle data", seq_err, 1);

      // R1: start clears error and raises init
      send_cmd(8'h21, 8'h07, 8'h00);
      check("R1 init raised", tgt_init, 1);
      check("R1 err cleared", seq_err, 0);

      // R9: bad lead byte
      send_byte(8'h55);
      check("R9 bad lead sets err", seq_err, 1);
      send_cmd(8'h21, 8'h00, 8'h00);

      // R5: data packet while waiting for ready
      send_data(1, 9, PLEN, 0);
      cmp_cfg("R5 wait drop");
      check("R5 err in wait", seq_err, 1);
      send_cmd(8'h21, 8'h00, 8'h00);

      // R2: program ready moves to loading
      tgt_prog_rdy = 1'b1;
      repeat (SYNC + 2) @(posedge clk); #1;
      check("R2 init held", tgt_init, 1);

      // R3: full packet, steady ready
      send_data(0, 3, PLEN, 1);
      cmp_cfg("R3 steady");

      // R3/R4: short chunk padded, random backpressure
      cfg_rnd = 1;
      send_data(1, 5, 23, 1);
      cfg_rnd = 0;
      cmp_cfg("R4 backpressure pad");

      // R9: bad terminator ignored; R10: unknown command ignored
      send_cmd(8'h21, 8'h00, 8'h05);
      check("R9 bad term sets err", seq_err, 1);
      check("R9 init kept", tgt_init, 1);
      send_cmd(8'h30, 8'h11, 8'h00);
      check("R10 err unchanged", seq_err, 1);
      check("R10 init unchanged", tgt_init, 1);
      send_data(0, 200, PLEN, 1);
      cmp_cfg("R10 still loading");

      // R6: end, done arrives inside window
      tgt_prog_rdy = 1'b0;
      rsp_rnd = 1;
      send_cmd(8'h23, 8'h00, 8'h00);
      check("R6 init released", tgt_init, 0);
      repeat (10) @(posedge clk); #1;
      tgt_done = 1'b1;
      read_rsp(1, "R6");

      // R7: done never arrives
      tgt_done = 1'b0;
      rsp_rnd = 0;
      send_cmd(8'h21, 8'h00, 8'h00);
      tgt_prog_rdy = 1'b1;
      repeat (SYNC + 2) @(posedge clk); #1;
      send_cmd(8'h23, 8'h00, 8'h00);
      check("R7 init released", tgt_init, 0);
      read_rsp(0, "R7");
      repeat (3) @(posedge clk); #1;
      check("R8 back to idle in_ready", in_ready, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule